// File: doc/BRIEF.md
# Machine Check Exception Controller

This block sits beside a processor core and turns machine-check events into an interrupt entry. Three kinds of cause arrive on separate inputs: error reports, which carry a faulting address; a non-maskable interrupt; and asynchronous machine-check sources. Each cause sets a bit in a sticky syndrome register. The block then decides whether to enter the handler.

On entry it saves the current program counter and the machine state word into a dedicated pair of save/restore registers. It forces the control bits of the state word to zero and redirects fetch to a handler address built from a prefix and an offset. A return strobe reverses the entry: fetch goes back to the saved PC and the saved state word is restored.

Software access to the syndrome register and to the state word is modelled as simple write ports. Instruction decode and the pipeline are modelled as the PC input and the return strobe.

Top module: `mchk_unit`

## Requirements
- R1: An error-report pulse or an NMI pulse causes an entry in the next cycle whether the machine-check-enable bit (state bit 12) is 0 or 1.
- R2: Asynchronous sources are always recorded in the syndrome. They cause an entry only while state bit 12 is 1, and a source recorded while the bit was 0 causes an entry once software sets the bit.
- R3: On entry, save register 0 receives `pcIn` and save register 1 receives the whole state word as it stood in the cycle of the entry.
- R4: On entry, state bits 1, 2, 4, 5, 8, 11, 12, 13, 14, 15, 17, 18, 25 and 26 become 0. Bit 9 becomes 0 when `deClearCfg` is 1 and keeps its value when it is 0. All other bits keep their values.
- R5: Syndrome layout: bits [ERR_W-1:0] hold the error reports, bit ERR_W holds the NMI, and the bits above it hold the asynchronous sources. Hardware only sets bits. `synClrWe` clears the bits selected by `synClrMask`. A bit being set by hardware in the same cycle stays set.
- R6: One cycle after an entry, `redirectValid` is 1 and `redirectPc` is `{vecPrefix[31:16], vecOffset[15:4], 4'b0000}`.
- R7: A return strobe makes `redirectValid` 1 and `redirectPc` equal to save register 0 in the next cycle, and it loads the state word from save register 1. If an entry happens in the same cycle, the entry is performed and the return is dropped.
- R8: Because state bit 1 (recoverable) is cleared on entry, a second entry before software sets the bit again leaves 0 in bit 1 of save register 1.
- R9: Causes present in the same cycle produce a single entry, and all of their syndrome bits are recorded together.
- R10: The address register loads `errAddr` only on an entry that includes an error report. Otherwise it holds its value.
- R11: After reset, the state word equals MSR_RESET (default 0). The save registers, syndrome, address register and redirect outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| errReport | input | ERR_W | Error-report cause pulses |
| errAddr | input | 32 | Address carried by an error report |
| nmi | input | 1 | Non-maskable interrupt pulse |
| asyncIn | input | ASYNC_W | Asynchronous machine-check sources |
| pcIn | input | 32 | Address of the instruction in flight |
| retStrobe | input | 1 | Return-from-machine-check strobe |
| msrWe | input | 1 | Software write of the state word |
| msrWdata | input | 32 | Data for the state-word write |
| synClrWe | input | 1 | Software write-1-to-clear of the syndrome |
| synClrMask | input | SYN_W | Syndrome bits to clear |
| deClearCfg | input | 1 | Clear the debug-enable bit on entry |
| vecPrefix | input | 32 | Vector prefix register |
| vecOffset | input | 32 | Machine-check vector offset register |
| redirectValid | output | 1 | Fetch redirect valid |
| redirectPc | output | 32 | Fetch redirect address |
| msrOut | output | 32 | State word |
| srr0Out | output | 32 | Save register 0 (PC) |
| srr1Out | output | 32 | Save register 1 (state word) |
| synOut | output | SYN_W | Syndrome register |
| addrOut | output | 32 | Machine-check address register |

## Verification
Two pairs of events can land in the same cycle. A software syndrome clear can meet a hardware set of the same bit, and a return strobe can meet a fresh cause. The bench drives a full-mask clear together with an error report, and a return strobe together with an NMI. It then compares the syndrome, the save registers and the redirect target with its own model, which keeps the set bit and performs the entry instead of the return.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int ADDR_W = 32;
  localparam int MSR_W  = 32;

  localparam int BIT_MCHK_EN = 12;
  localparam int BIT_DEBUG   = 9;
  localparam int BIT_RECOV   = 1;

  // control bits forced to zero on entry (debug-enable handled separately)
  localparam logic [MSR_W-1:0] ENTRY_CLEAR = 32'h0606_F936;
  localparam logic [MSR_W-1:0] DEBUG_MASK  = 32'h0000_0200;

  typedef struct packed {
    logic entry;
    logic ret;
    logic swMsr;
    logic ldAddr;
  } mchkStrobe_t;
endpackage

// File: rtl/mchk_ctrl.sv
module mchk_ctrl
  import mchk_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int ASYNC_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ERR_W-1:0]   errReport,
  input  logic               nmi,
  input  logic [ASYNC_W-1:0] asyncIn,
  input  logic [ASYNC_W-1:0] synAsync,
  input  logic               msrMchkEn,
  input  logic               retStrobe,
  input  logic               msrWe,
  output mchkStrobe_t        strobe
);
  logic errHit;
  logic asyncHit;
  logic maskedHit;

  assign errHit    = |errReport;
  assign asyncHit  = |(asyncIn | synAsync);
  assign maskedHit = errHit | nmi;

  always_comb begin
    strobe        = '0;
    strobe.entry  = !rst && (maskedHit || (msrMchkEn && asyncHit));
    strobe.ret    = !rst && retStrobe && !strobe.entry;
    strobe.swMsr  = !rst && msrWe && !strobe.entry && !strobe.ret;
    strobe.ldAddr = strobe.entry && errHit;
  end

  // R2: with the enable bit low, only unmaskable causes enter
  a_r2_async_gated: assert property (@(posedge clk) disable iff (rst)
    (!msrMchkEn && !maskedHit) |-> !strobe.entry);

  // R1: error reports and NMI always enter
  a_r1_unmaskable: assert property (@(posedge clk) disable iff (rst)
    maskedHit |-> strobe.entry);

  // R7: at most one state-word update per cycle
  a_r7_one_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.entry, strobe.ret, strobe.swMsr}));
endmodule

// File: rtl/mchk_datapath.sv
module mchk_datapath
  import mchk_pkg::*;
#(
  parameter int               ERR_W     = 4,
  parameter int               ASYNC_W   = 3,
  parameter logic [MSR_W-1:0] MSR_RESET = '0,
  localparam int              SYN_W     = ERR_W + 1 + ASYNC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  mchkStrobe_t        strobe,
  input  logic [ERR_W-1:0]   errReport,
  input  logic [ADDR_W-1:0]  errAddr,
  input  logic               nmi,
  input  logic [ASYNC_W-1:0] asyncIn,
  input  logic [ADDR_W-1:0]  pcIn,
  input  logic [MSR_W-1:0]   msrWdata,
  input  logic               synClrWe,
  input  logic [SYN_W-1:0]   synClrMask,
  input  logic               deClearCfg,
  input  logic [ADDR_W-1:0]  vecPrefix,
  input  logic [ADDR_W-1:0]  vecOffset,
  output logic [ASYNC_W-1:0] synAsync,
  output logic               msrMchkEn,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectPc,
  output logic [MSR_W-1:0]   msrOut,
  output logic [ADDR_W-1:0]  srr0Out,
  output logic [MSR_W-1:0]   srr1Out,
  output logic [SYN_W-1:0]   synOut,
  output logic [ADDR_W-1:0]  addrOut
);
  logic [MSR_W-1:0]  msrQ, srr1Q, entryMsr;
  logic [ADDR_W-1:0] srr0Q, addrQ, redPcQ, vector;
  logic [SYN_W-1:0]  synQ, synSet, synClr;
  logic              redValidQ;

  assign vector   = {vecPrefix[31:16], vecOffset[15:4], 4'b0000};
  assign synSet   = {asyncIn, nmi, errReport};
  assign synClr   = synClrWe ? synClrMask : '0;
  assign entryMsr = msrQ & ~ENTRY_CLEAR & ~(deClearCfg ? DEBUG_MASK : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      msrQ      <= MSR_RESET;
      srr0Q     <= '0;
      srr1Q     <= '0;
      synQ      <= '0;
      addrQ     <= '0;
      redValidQ <= 1'b0;
      redPcQ    <= '0;
    end else begin
      synQ      <= (synQ & ~synClr) | synSet;
      redValidQ <= strobe.entry || strobe.ret;
      if (strobe.entry) begin
        srr0Q  <= pcIn;
        srr1Q  <= msrQ;
        msrQ   <= entryMsr;
        redPcQ <= vector;
      end else if (strobe.ret) begin
        msrQ   <= srr1Q;
        redPcQ <= srr0Q;
      end else if (strobe.swMsr) begin
        msrQ   <= msrWdata;
      end
      if (strobe.ldAddr) addrQ <= errAddr;
    end
  end

  assign synAsync      = synQ[SYN_W-1:ERR_W+1];
  assign msrMchkEn     = msrQ[BIT_MCHK_EN];
  assign redirectValid = redValidQ;
  assign redirectPc    = redPcQ;
  assign msrOut        = msrQ;
  assign srr0Out       = srr0Q;
  assign srr1Out       = srr1Q;
  assign synOut        = synQ;
  assign addrOut       = addrQ;

  // R5: hardware never drops a syndrome bit
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(synClrWe) |-> ((synQ & $past(synQ)) == $past(synQ)));

  // R3: saved context matches the cycle of entry
  a_r3_saved: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.entry) |-> (srr1Q == $past(msrQ)) && (srr0Q == $past(pcIn)));

  // R4 / R8: enable and recoverable bits are low after entry
  a_r4_bits_low: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.entry) |-> !msrQ[BIT_MCHK_EN] && !msrQ[BIT_RECOV]);

  // R6: redirect to the handler vector
  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.entry) |-> redValidQ && (redPcQ == $past(vector)));

  // R7: return restores the saved context
  a_r7_restore: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.ret) |-> (msrQ == $past(srr1Q)) && (redPcQ == $past(srr0Q)));

  // R10: the address register holds unless an error report enters
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.ldAddr) |-> $stable(addrQ));
endmodule

// File: rtl/mchk_unit.sv
module mchk_unit
  import mchk_pkg::*;
#(
  parameter int               ERR_W     = 4,
  parameter int               ASYNC_W   = 3,
  parameter logic [MSR_W-1:0] MSR_RESET = '0,
  localparam int              SYN_W     = ERR_W + 1 + ASYNC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ERR_W-1:0]   errReport,
  input  logic [31:0]        errAddr,
  input  logic               nmi,
  input  logic [ASYNC_W-1:0] asyncIn,
  input  logic [31:0]        pcIn,
  input  logic               retStrobe,
  input  logic               msrWe,
  input  logic [31:0]        msrWdata,
  input  logic               synClrWe,
  input  logic [SYN_W-1:0]   synClrMask,
  input  logic               deClearCfg,
  input  logic [31:0]        vecPrefix,
  input  logic [31:0]        vecOffset,
  output logic               redirectValid,
  output logic [31:0]        redirectPc,
  output logic [31:0]        msrOut,
  output logic [31:0]        srr0Out,
  output logic [31:0]        srr1Out,
  output logic [SYN_W-1:0]   synOut,
  output logic [31:0]        addrOut
);
  mchkStrobe_t        strobe;
  logic [ASYNC_W-1:0] synAsync;
  logic               msrMchkEn;

  mchk_ctrl #(.ERR_W(ERR_W), .ASYNC_W(ASYNC_W)) u_ctrl (
    .clk(clk), .rst(rst), .errReport(errReport), .nmi(nmi),
    .asyncIn(asyncIn), .synAsync(synAsync), .msrMchkEn(msrMchkEn),
    .retStrobe(retStrobe), .msrWe(msrWe), .strobe(strobe)
  );

  mchk_datapath #(.ERR_W(ERR_W), .ASYNC_W(ASYNC_W), .MSR_RESET(MSR_RESET)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .errReport(errReport),
    .errAddr(errAddr), .nmi(nmi), .asyncIn(asyncIn), .pcIn(pcIn),
    .msrWdata(msrWdata), .synClrWe(synClrWe), .synClrMask(synClrMask),
    .deClearCfg(deClearCfg), .vecPrefix(vecPrefix), .vecOffset(vecOffset),
    .synAsync(synAsync), .msrMchkEn(msrMchkEn),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .msrOut(msrOut), .srr0Out(srr0Out), .srr1Out(srr1Out),
    .synOut(synOut), .addrOut(addrOut)
  );
endmodule

// File: tb/mchk_unit_bench.sv
module mchk_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 4;
  localparam int AW = 3;
  localparam int SW = EW + 1 + AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [EW-1:0] errReport = '0;
  logic [31:0]   errAddr = '0;
  logic          nmi = 1'b0;
  logic [AW-1:0] asyncIn = '0;
  logic [31:0]   pcIn = '0;
  logic          retStrobe = 1'b0;
  logic          msrWe = 1'b0;
  logic [31:0]   msrWdata = '0;
  logic          synClrWe = 1'b0;
  logic [SW-1:0] synClrMask = '0;
  logic          deClearCfg = 1'b0;
  logic [31:0]   vecPrefix = 32'hA5C3_0000;
  logic [31:0]   vecOffset = 32'h0000_0120;
  logic          redirectValid;
  logic [31:0]   redirectPc, msrOut, srr0Out, srr1Out, addrOut;
  logic [SW-1:0] synOut;

  mchk_unit u_mchk_unit (
    .clk(clk), .rst(rst), .errReport(errReport), .errAddr(errAddr), .nmi(nmi),
    .asyncIn(asyncIn), .pcIn(pcIn), .retStrobe(retStrobe), .msrWe(msrWe),
    .msrWdata(msrWdata), .synClrWe(synClrWe), .synClrMask(synClrMask),
    .deClearCfg(deClearCfg), .vecPrefix(vecPrefix), .vecOffset(vecOffset),
    .redirectValid(redirectValid), .redirectPc(redirectPc), .msrOut(msrOut),
    .srr0Out(srr0Out), .srr1Out(srr1Out), .synOut(synOut), .addrOut(addrOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    started = 0;
  bit    done = 0;
  string curReq = "R11";

  // reference model state
  logic [31:0]   mMsr, mSrr0, mSrr1, mAddr, mRedPc;
  logic [SW-1:0] mSyn;
  logic          mRedV;
  int            zeroBits[14] = '{26, 25, 18, 17, 15, 14, 13, 12, 11, 8, 5, 4, 2, 1};

  function automatic logic [31:0] afterEntry(logic [31:0] m, logic de);
    logic [31:0] r = m;
    foreach (zeroBits[i]) r[zeroBits[i]] = 1'b0;
    if (de) r[9] = 1'b0;
    return r;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mMsr = '0; mSrr0 = '0; mSrr1 = '0; mAddr = '0;
      mRedPc = '0; mSyn = '0; mRedV = 0;
    end else begin
      logic take;
      logic [AW-1:0] storedAsync;
      storedAsync = mSyn[SW-1:EW+1];
      take = (errReport != 0) || nmi || (mMsr[12] && ((storedAsync | asyncIn) != 0));
      if (synClrWe) mSyn = mSyn & ~synClrMask;
      mSyn = mSyn | {asyncIn, nmi, errReport};
      if (take) begin
        mSrr0 = pcIn;
        mSrr1 = mMsr;
        mMsr = afterEntry(mMsr, deClearCfg);
        mRedV = 1;
        mRedPc = {vecPrefix[31:16], vecOffset[15:4], 4'h0};
        if (errReport != 0) mAddr = errAddr;
      end else if (retStrobe) begin
        mMsr = mSrr1;
        mRedV = 1;
        mRedPc = mSrr0;
      end else begin
        mRedV = 0;
        if (msrWe) mMsr = msrWdata;
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("redirectValid", {31'b0, redirectValid}, {31'b0, mRedV});
      cmp("redirectPc", redirectPc, mRedPc);
      cmp("msr", msrOut, mMsr);
      cmp("srr0", srr0Out, mSrr0);
      cmp("srr1", srr1Out, mSrr1);
      cmp("syndrome", {{(32-SW){1'b0}}, synOut}, {{(32-SW){1'b0}}, mSyn});
      cmp("addr", addrOut, mAddr);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    errReport = '0; nmi = 0; asyncIn = '0; retStrobe = 0;
    msrWe = 0; synClrWe = 0; synClrMask = '0;
    pcIn = pcIn + 32'h4;
  endtask

  task automatic clearSyn();
    synClrWe = 1; synClrMask = '1; tick();
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    pcIn = 32'h0000_1000;
    repeat (3) tick();
    rst = 0;
    curReq = "R11"; tick(); tick();

    curReq = "R2";
    asyncIn = 3'b010; tick(); tick();              // recorded, not taken
    msrWe = 1; msrWdata = 32'h0000_1002; tick();   // enable -> entry follows
    tick(); tick();

    curReq = "R5";
    clearSyn(); tick();
    synClrWe = 1; synClrMask = '1; errReport = 4'b0001; errAddr = 32'h0BAD_0001; tick();
    tick();

    curReq = "R1";
    errReport = 4'b0100; errAddr = 32'hDEAD_0040; tick(); tick();
    nmi = 1; tick(); tick();

    curReq = "R4";
    msrWe = 1; msrWdata = 32'hFFFF_FFFF; deClearCfg = 0; tick();
    clearSyn();
    nmi = 1; tick(); tick();
    msrWe = 1; msrWdata = 32'hFFFF_FFFF; deClearCfg = 1; tick();
    nmi = 1; tick(); tick();
    msrWe = 1; msrWdata = 32'h5A5A_A5A5; deClearCfg = 0; tick();
    errReport = 4'b1000; errAddr = 32'h1234_5678; tick(); tick();

    curReq = "R6";
    vecPrefix = 32'h7E81_FFFF; vecOffset = 32'hFFFF_ABCF; nmi = 1; tick(); tick();
    vecPrefix = 32'h0001_0000; vecOffset = 32'h0000_0010; errReport = 4'b0010; tick(); tick();

    curReq = "R3";
    msrWe = 1; msrWdata = 32'h0000_3A0C; tick();
    pcIn = 32'hCAFE_0100; nmi = 1; tick(); tick();

    curReq = "R7";
    clearSyn();
    retStrobe = 1; tick(); tick();
    retStrobe = 1; nmi = 1; tick(); tick();
    clearSyn();
    retStrobe = 1; tick(); tick();

    curReq = "R8";
    clearSyn();
    msrWe = 1; msrWdata = 32'h0000_0002; tick();
    errReport = 4'b0001; errAddr = 32'h0000_0AA0; tick();
    errReport = 4'b0010; errAddr = 32'h0000_0BB0; tick(); tick();

    curReq = "R9";
    clearSyn();
    msrWe = 1; msrWdata = 32'h0000_1000; tick();
    errReport = 4'b0101; nmi = 1; asyncIn = 3'b100; errAddr = 32'h0F0F_0F0F; tick(); tick();

    curReq = "R10";
    clearSyn();
    errAddr = 32'hFFFF_0000; nmi = 1; tick(); tick();
    msrWe = 1; msrWdata = 32'h0000_1000; tick();
    asyncIn = 3'b001; errAddr = 32'h1111_2222; tick(); tick();
    clearSyn(); tick();

    done = 1;
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      finishRun();
    end
  end
endmodule